// File: doc/BRIEF.md
# JTAG Debug Scan Selector with Instruction Issue

This block is the target-side debug logic that sits behind a JTAG test access port. It contains the full IEEE 1149.1 TAP controller, a 5-bit instruction register and a 5-bit chain-select register. The chain-select register is written by scanning a chain number while a dedicated select instruction is loaded. A host uses it to read an identification word, to bypass the device, to pick a scan chain, and to load a 32-bit processor opcode into an instruction-transfer chain.

The opcode goes to the processor core as a one-cycle issue pulse. The pulse fires on the TCK cycle in which the controller arrives in Run-Test/Idle from another state. It fires only when the chain and instruction conditions allow it. The core answers with a completion strobe, which sets a flag that the host can read back as the last bit of the instruction-transfer scan. All shifting and capturing happen on the rising edge of TCK. TDO changes on the falling edge.

Top module: `dbg_scan_exec`

## Requirements
- R1: Five consecutive rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state, and every state follows the IEEE 1149.1 transition graph.
- R2: In Test-Logic-Reset the instruction register becomes IDCODE (5'h1E) and the chain select becomes 0. Capture-IR loads 5'b00001, shifted out LSB first.
- R3: Under IDCODE the data path is 32 bits and captures the IDCODE parameter, LSB first. Under BYPASS (5'h1F) and under any unlisted code, the data path is a single bit that captures 0.
- R4: Under the select instruction (5'h02) the data path is 5 bits. Capture-DR loads 5'h10. The chain select takes the shifted value only at Update-DR.
- R5: The instruction-transfer path is 33 bits. The first 32 bits shifted out are the latched opcode, LSB first, and the 33rd bit is the completion flag. Update-DR latches the first 32 bits shifted in as the new opcode, which is presented on `core_op`. The path is active under the shortcut instruction (5'h1D), or under internal test (5'h0C) or external test (5'h00) with chain 4.
- R6: `core_issue` is high for exactly one TCK cycle on arrival in Run-Test/Idle from another state. This happens when the instruction register holds internal test or external test and the chain is 4 or 5, or when it holds the shortcut instruction.
- R7: Remaining in Run-Test/Idle for further cycles issues nothing more. A new issue needs the controller to leave Run-Test/Idle and come back.
- R8: With chain 0 selected, internal test and external test never issue, however often Run-Test/Idle is entered.
- R9: The completion flag is 1 after `trst_n`. It clears in the cycle after an issue and sets in the cycle after `core_done` is high without an issue.
- R10: TDO changes only on the falling edge of TCK and is 0 outside Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| core_op | output | OP_W | Latched opcode presented to the core |
| core_issue | output | 1 | One-cycle request to execute `core_op` |
| core_done | input | 1 | Completion strobe from the core |

## Verification
The bench holds the controller in Run-Test/Idle after an issue. A design that re-armed on every idle cycle would issue the opcode again in each of those cycles. It then leaves and re-enters the state, and expects exactly one more issue. It reads the transfer chain while the core model is still busy and again after completion. A flag that ignored the issue, or that was captured in the wrong bit position, shows up as a wrong 33rd bit. It checks that chain 0 blocks issue under internal test, while chain 5 with external test and the shortcut instruction both issue. It also checks that a reset taken mid-scan restores IDCODE and chain 0. A monitor confirms that TDO never moves just after a rising edge, which catches a shift stage clocked on the wrong edge.

// File: rtl/dbg_scan_pkg.sv
`timescale 1ns/1ps
package dbg_scan_pkg;
  localparam int IR_W = 5;
  localparam int CH_W = 5;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_SELECT, DR_INSTR} dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXT    = 5'h00;
  localparam logic [IR_W-1:0] OP_SEL    = 5'h02;
  localparam logic [IR_W-1:0] OP_INT    = 5'h0C;
  localparam logic [IR_W-1:0] OP_ITR    = 5'h1D;
  localparam logic [IR_W-1:0] OP_IDCODE = 5'h1E;
  localparam logic [IR_W-1:0] OP_BYPASS = 5'h1F;

  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;
  localparam logic [CH_W-1:0] SEL_SIGNATURE = 5'h10;
  localparam logic [CH_W-1:0] CH_INSTR = 5'd4;
  localparam logic [CH_W-1:0] CH_DATA  = 5'd5;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      TS_RESET:    return m ? TS_RESET    : TS_IDLE;
      TS_IDLE:     return m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   return m ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   return m ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: return m ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: return m ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: return m ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: return m ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   return m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   return m ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   return m ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: return m ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: return m ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: return m ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: return m ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   return m ? TS_SEL_DR   : TS_IDLE;
      default:     return TS_RESET;
    endcase
  endfunction

  function automatic logic exec_mode(input logic [IR_W-1:0] ir, input logic [CH_W-1:0] ch);
    return (ir == OP_ITR) ||
           (((ir == OP_INT) || (ir == OP_EXT)) && ((ch == CH_INSTR) || (ch == CH_DATA)));
  endfunction

  function automatic dr_sel_e dr_pick(input logic [IR_W-1:0] ir, input logic [CH_W-1:0] ch);
    if (ir == OP_IDCODE) return DR_IDCODE;
    if (ir == OP_SEL) return DR_SELECT;
    if (ir == OP_ITR) return DR_INSTR;
    if (((ir == OP_INT) || (ir == OP_EXT)) && (ch == CH_INSTR)) return DR_INSTR;
    return DR_BYPASS;
  endfunction

  function automatic int dr_length(input dr_sel_e s, input int op_w);
    case (s)
      DR_IDCODE: return 32;
      DR_SELECT: return CH_W;
      DR_INSTR:  return op_w + 1;
      default:   return 1;
    endcase
  endfunction
endpackage

// File: rtl/dbg_tap_fsm.sv
`timescale 1ns/1ps
module dbg_tap_fsm
  import dbg_scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state,
  output tap_state_e prev_state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state      <= TS_RESET;
      prev_state <= TS_RESET;
    end else begin
      state      <= tap_next(state, tms);
      prev_state <= state;
    end
  end
endmodule

// File: rtl/dbg_ir_reg.sv
`timescale 1ns/1ps
module dbg_ir_reg
  import dbg_scan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir,
  output logic            ir_tdo
);
  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir    <= OP_IDCODE;
      ir_sr <= '0;
    end else begin
      case (state)
        TS_RESET:    ir    <= OP_IDCODE;
        TS_CAP_IR:   ir_sr <= IR_CAPTURE;
        TS_SHIFT_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        TS_UPD_IR:   ir    <= ir_sr;
        default: ;
      endcase
    end
  end

  assign ir_tdo = ir_sr[0];
endmodule

// File: rtl/dbg_dr_path.sv
`timescale 1ns/1ps
module dbg_dr_path
  import dbg_scan_pkg::*;
#(
  parameter int          OP_W   = 32,
  parameter logic [31:0] IDCODE = 32'h0B57_7E3D
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  input  logic [IR_W-1:0] ir,
  input  logic            done_flag,
  output logic [CH_W-1:0] chain,
  output logic [OP_W-1:0] opcode,
  output logic            dr_tdo,
  output logic [CH_W-1:0] dr_low
);
  localparam int SR_W = (OP_W + 1 > 33) ? OP_W + 1 : 33;

  logic [SR_W-1:0] sr;
  dr_sel_e         sel;
  int              len;

  assign sel = dr_pick(ir, chain);
  assign len = dr_length(sel, OP_W);

  function automatic logic [SR_W-1:0] shift_in(input logic [SR_W-1:0] v, input logic b,
                                                input int n);
    logic [SR_W-1:0] t;
    t = v >> 1;
    t[n-1] = b;
    return t;
  endfunction

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr     <= '0;
      chain  <= '0;
      opcode <= '0;
    end else begin
      case (state)
        TS_RESET: chain <= '0;
        TS_CAP_DR: begin
          case (sel)
            DR_IDCODE: sr <= SR_W'(IDCODE);
            DR_SELECT: sr <= SR_W'(SEL_SIGNATURE);
            DR_INSTR:  sr <= SR_W'({done_flag, opcode});
            default:   sr <= '0;
          endcase
        end
        TS_SHIFT_DR: sr <= shift_in(sr, tdi, len);
        TS_UPD_DR: begin
          if (sel == DR_SELECT) chain  <= sr[CH_W-1:0];
          if (sel == DR_INSTR)  opcode <= sr[OP_W-1:0];
        end
        default: ;
      endcase
    end
  end

  assign dr_tdo = sr[0];
  assign dr_low = sr[CH_W-1:0];
endmodule

// File: rtl/dbg_issue_ctl.sv
`timescale 1ns/1ps
module dbg_issue_ctl
  import dbg_scan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  tap_state_e      prev_state,
  input  logic [IR_W-1:0] ir,
  input  logic [CH_W-1:0] chain,
  input  logic            core_done,
  output logic            core_issue,
  output logic            done_flag
);
  logic idle_arrival;

  assign idle_arrival = (state == TS_IDLE) && (prev_state != TS_IDLE);
  assign core_issue   = idle_arrival && exec_mode(ir, chain);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         done_flag <= 1'b1;
    else if (core_issue) done_flag <= 1'b0;
    else if (core_done)  done_flag <= 1'b1;
  end
endmodule

// File: rtl/dbg_scan_exec.sv
`timescale 1ns/1ps
module dbg_scan_exec
  import dbg_scan_pkg::*;
#(
  parameter int          OP_W   = 32,
  parameter logic [31:0] IDCODE = 32'h0B57_7E3D
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic [OP_W-1:0] core_op,
  output logic            core_issue,
  input  logic            core_done
);
  tap_state_e      tap_state, tap_prev;
  logic [IR_W-1:0] ir_q;
  logic [CH_W-1:0] chain_q, dr_low;
  logic            ir_tdo, dr_tdo, done_flag;

  dbg_tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_state), .prev_state(tap_prev)
  );

  dbg_ir_reg u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_state), .ir(ir_q), .ir_tdo(ir_tdo)
  );

  dbg_dr_path #(.OP_W(OP_W), .IDCODE(IDCODE)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_state), .ir(ir_q),
    .done_flag(done_flag), .chain(chain_q), .opcode(core_op), .dr_tdo(dr_tdo),
    .dr_low(dr_low)
  );

  dbg_issue_ctl u_issue (
    .tck(tck), .trst_n(trst_n), .state(tap_state), .prev_state(tap_prev), .ir(ir_q),
    .chain(chain_q), .core_done(core_done), .core_issue(core_issue), .done_flag(done_flag)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                         tdo <= 1'b0;
    else if (tap_state == TS_SHIFT_IR)   tdo <= ir_tdo;
    else if (tap_state == TS_SHIFT_DR)   tdo <= dr_tdo;
    else                                 tdo <= 1'b0;
  end
endmodule

// File: rtl/dbg_scan_exec_chk.sv
`timescale 1ns/1ps
module dbg_scan_exec_chk
  import dbg_scan_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_e      state,
  input tap_state_e      prev_state,
  input logic [IR_W-1:0] ir,
  input logic [CH_W-1:0] chain,
  input logic            core_issue,
  input logic            core_done,
  input logic            done_flag,
  input logic [CH_W-1:0] dr_low
);
  logic [2:0] ones;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     ones <= '0;
    else if (!tms)   ones <= '0;
    else if (ones != 3'd7) ones <= ones + 3'd1;
  end

  a_r1_five_ones: assert property (@(posedge tck) disable iff (!trst_n)
    (ones >= 3'd5) |-> (state == TS_RESET));

  a_r2_reset_values: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET) |=> (ir == OP_IDCODE) && (chain == '0));

  a_r4_sel_signature: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAP_DR && ir == OP_SEL) |=> (dr_low == SEL_SIGNATURE));

  a_r4_chain_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (!(state == TS_UPD_DR && ir == OP_SEL) && state != TS_RESET) |=> $stable(chain));

  a_r6_issue_mode: assert property (@(posedge tck) disable iff (!trst_n)
    core_issue |-> (ir != OP_IDCODE) && (ir != OP_BYPASS) && (ir != OP_SEL));

  a_r6_issue_from_other: assert property (@(posedge tck) disable iff (!trst_n)
    core_issue |-> (prev_state != state));

  a_r7_single_issue: assert property (@(posedge tck) disable iff (!trst_n)
    core_issue |=> !core_issue);

  a_r8_chain0_quiet: assert property (@(posedge tck) disable iff (!trst_n)
    (chain == '0 && ir != OP_ITR) |-> !core_issue);

  a_r9_flag_clear: assert property (@(posedge tck) disable iff (!trst_n)
    core_issue |=> !done_flag);

  a_r9_flag_set: assert property (@(posedge tck) disable iff (!trst_n)
    (core_done && !core_issue) |=> done_flag);
endmodule

bind dbg_scan_exec dbg_scan_exec_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_state), .prev_state(tap_prev),
  .ir(ir_q), .chain(chain_q), .core_issue(core_issue), .core_done(core_done),
  .done_flag(done_flag), .dr_low(dr_low)
);

// File: tb/test_dbg_scan_exec.sv
`timescale 1ns/1ps
module test_dbg_scan_exec;
  localparam logic [31:0] ID_VAL = 32'h0B57_7E3D;
  localparam int CORE_LAT = 20;
  localparam logic [4:0] C_EXT = 5'h00, C_SEL = 5'h02, C_INT = 5'h0C;
  localparam logic [4:0] C_ITR = 5'h1D, C_BYP = 5'h1F;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, tdo, core_issue, core_done = 1'b0;
  logic [31:0] core_op;
  int checks = 0, errors = 0, issue_cnt = 0, busy = 0, tdo_moves = 0;
  logic [31:0] last_op = '0;
  bit finished = 0;

  always #2.5 tck = ~tck;

  dbg_scan_exec #(.OP_W(32), .IDCODE(ID_VAL)) i_dbg_scan_exec (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .core_op(core_op), .core_issue(core_issue), .core_done(core_done)
  );

  // core model: counts issues, answers after CORE_LAT cycles
  always @(negedge tck) begin
    if (core_issue) begin
      issue_cnt++; last_op = core_op; busy = CORE_LAT; core_done = 1'b0;
    end else if (busy > 0) begin
      busy--; if (busy == 0) core_done = 1'b1;
    end else core_done = 1'b0;
  end

  // R10 monitor: tdo must not move right after a rising edge
  always @(posedge tck) begin
    logic t0;
    t0 = tdo;
    #1;
    if (trst_n && tdo !== t0) tdo_moves++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo; tms = m; tdi = d;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
  endtask

  task automatic ir_scan(input logic [4:0] v, input bit to_dr, output logic [4:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, v[i], o); cap[i] = o;
    end
    step(1, 0, o);
    step(to_dr, 0, o);
  endtask

  task automatic dr_scan(input int len, input logic [63:0] din, input bit from_sel,
                         output logic [63:0] dout);
    logic o;
    dout = '0;
    if (!from_sel) step(1, 0, o);
    step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], o); dout[i] = o;
    end
    step(1, 0, o);
    step(0, 0, o);
  endtask

  task automatic reenter();
    logic o;
    step(1, 0, o); step(0, 0, o); step(1, 0, o); step(1, 0, o); step(0, 0, o);
  endtask

  task automatic t_reset();
    chk("R10 tdo after reset", tdo, 0);
    chk("R6 no issue after reset", core_issue, 0);
    idle(2);
  endtask

  task automatic t_idcode();
    logic [63:0] d; logic [4:0] c;
    dr_scan(32, 64'h0, 0, d);
    chk("R2 reset IR selects idcode path", d[31:0], ID_VAL);
    ir_scan(5'h1E, 0, c);
    chk("R2 IR capture pattern", c, 5'b00001);
    dr_scan(32, 64'hFFFF_FFFF, 0, d);
    chk("R3 idcode value", d[31:0], ID_VAL);
  endtask

  task automatic t_bypass();
    logic [63:0] d; logic [4:0] c;
    ir_scan(C_BYP, 0, c);
    dr_scan(8, 64'hA5, 0, d);
    chk("R3 bypass one-bit delay", d[7:0], {8'hA5 << 1});
  endtask

  task automatic t_select();
    logic [63:0] d; logic [4:0] c;
    ir_scan(C_SEL, 0, c);
    dr_scan(5, 64'd4, 0, d);
    chk("R4 select capture signature", d[4:0], 5'h10);
    dr_scan(5, 64'd4, 0, d);
    chk("R4 signature not chain value", d[4:0], 5'h10);
  endtask

  task automatic t_issue();
    logic [63:0] d; logic [4:0] c; int base;
    base = issue_cnt;
    ir_scan(C_INT, 1, c);
    dr_scan(33, {31'd0, 1'b0, 32'hE1A0_1002}, 1, d);
    chk("R9 flag set after reset", d[32], 1);
    chk("R5 opcode readback after reset", d[31:0], 0);
    idle(1);
    chk("R6 issue on idle arrival", issue_cnt - base, 1);
    chk("R5 issued opcode", last_op, 32'hE1A0_1002);
    dr_scan(33, {31'd0, 1'b0, 32'h1234_5678}, 0, d);
    chk("R5 opcode field first 32 bits", d[31:0], 32'hE1A0_1002);
    chk("R9 flag clear while core busy", d[32], 0);
    idle(1);
    chk("R6 second issue", issue_cnt - base, 2);
    idle(40);
    dr_scan(33, {31'd0, 1'b0, 32'h1234_5678}, 0, d);
    chk("R9 flag set after completion", d[32], 1);
    idle(1);
  endtask

  task automatic t_dwell();
    int base;
    base = issue_cnt;
    idle(10);
    chk("R7 no repeat while idling", issue_cnt - base, 0);
    reenter(); idle(1);
    chk("R7 re-entry issues once", issue_cnt - base, 1);
  endtask

  task automatic t_chain0();
    logic [63:0] d; logic [4:0] c; int base;
    ir_scan(C_SEL, 0, c);
    dr_scan(5, 64'd0, 0, d);
    base = issue_cnt;
    ir_scan(C_INT, 0, c); idle(1);
    chk("R8 chain 0 blocks internal test", issue_cnt - base, 0);
    reenter(); idle(1);
    chk("R8 chain 0 blocks re-entry", issue_cnt - base, 0);
    ir_scan(C_ITR, 0, c); idle(1);
    chk("R6 shortcut instruction issues", issue_cnt - base, 1);
    chk("R6 shortcut issues latched opcode", last_op, 32'h1234_5678);
  endtask

  task automatic t_chain5();
    logic [63:0] d; logic [4:0] c; int base;
    ir_scan(C_SEL, 0, c);
    dr_scan(5, 64'd5, 0, d);
    base = issue_cnt;
    ir_scan(C_EXT, 0, c); idle(1);
    chk("R6 chain 5 external test issues", issue_cnt - base, 1);
  endtask

  task automatic t_tlr();
    logic [63:0] d; logic [4:0] c; logic o; int base;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 5; i++) step(1, 0, o);
    step(0, 0, o);
    idle(1);
    dr_scan(32, 64'h0, 0, d);
    chk("R1 reset from shift restores idcode", d[31:0], ID_VAL);
    base = issue_cnt;
    ir_scan(C_INT, 0, c); idle(1);
    chk("R2 chain cleared by reset state", issue_cnt - base, 0);
    chk("R2 IR capture after reset", c, 5'b00001);
  endtask

  task automatic t_tdo();
    chk("R10 tdo low outside shift", tdo, 0);
    chk("R10 tdo moved after rising edge", tdo_moves, 0);
  endtask

  initial begin
    #12 trst_n = 1'b1;
    t_reset(); t_idcode(); t_bypass(); t_select(); t_issue();
    t_dwell(); t_chain0(); t_chain5(); t_tlr(); t_tdo();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule